// File: doc/BRIEF.md
# Rational-Ratio Accumulator Clock Divider

This block derives, from a reference clock, a pulse train whose long-run rate is exactly the reference rate scaled by a fixed fraction P/Q. The fraction is set by two elaboration-time parameters. The block first divides both by their greatest common divisor, so the accumulator is only as wide as the reduced denominator needs. With the default ratio 256/78125, a 10 MHz reference yields 32.768 kHz. The block can be seen as a special-purpose numerically controlled oscillator with a resolution of 128 Hz, set to 256 steps. Its sequence repeats every 78125 reference cycles (1/128 s).

The accumulator starts at Q. On every enabled cycle it loses P. When that step would take it to zero or below, the borrow out of the subtraction marks an overflow and Q is added back. No magnitude comparison against Q is made. Each overflow gives a single-cycle strobe. A square-wave output is high while the accumulator sits in the lower half of its range, which gives close to 50% duty at the divided rate. Both outputs are registered. A low run enable freezes the block. The sequence never drifts, so a clock motor or timekeeping circuit fed from it keeps the reference's long-term accuracy. The cost is at most one reference cycle of period jitter.

Top module: `ratdiv_top`

## Requirements
- R1: While rst is high at a rising edge, the accumulator reloads to Q, and after that edge ovf_pulse is 0 and sq_out is 0. Reset takes priority over run_en.
- R2: Let k be the number of edges with run_en high since reset. After the edge that makes the count k, ovf_pulse is 1 exactly when floor(k*P/Q) > floor((k-1)*P/Q), where P and Q are the reduced ratio. This gives P strobes in every Q enabled cycles.
- R3: ovf_pulse is never high on two consecutive cycles.
- R4: An edge with run_en low (and rst low) leaves the accumulator and sq_out unchanged and drives ovf_pulse to 0.
- R5: After the edge that makes the count k, sq_out is 1 exactly when Q - (k*P mod Q) < (Q+1)/2.
- R6: The number of enabled cycles from one strobe to the next, or from reset to the first strobe, is always floor(Q/P) or ceil(Q/P). For the default ratio that is 305 or 306.
- R7: After exactly Q enabled cycles from reset the accumulator is back at Q, and exactly P strobes have been produced. The whole output pattern then repeats.
- R8: The NUM/DEN parameters are reduced by their greatest common divisor before use. NUM=6, DEN=20 behaves exactly as 3/10, with the accumulator sized for 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Advance the accumulator on this edge |
| ovf_pulse | output | 1 | One-cycle strobe per accumulator overflow |
| sq_out | output | 1 | Divided square wave |

## Verification
The assertions assume that rst is high at the first rising edge, and that the parameters satisfy 0 < 2*NUM <= DEN. With that ratio strobes cannot fall on adjacent cycles, and the accumulator always stays between 1 and Q. run_en may follow any pattern. The gap checker counts only enabled cycles, so a gated run still has to show a gap of floor or ceil of Q/P. The stimulus starts in reset and changes inputs only on falling edges. It uses legal ratios only (the default, plus 6/20 to exercise the reduction), and mixes long free runs with irregular enable gating and a reset asserted together with enable.

// File: rtl/ratdiv_pkg.sv
`timescale 1ns/1ps
package ratdiv_pkg;

  // Greatest common divisor, evaluated at elaboration time.
  function automatic int unsigned gcd_u(input int unsigned a_in, input int unsigned b_in);
    int unsigned a;
    int unsigned b;
    int unsigned t;
    a = a_in;
    b = b_in;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

endpackage

// File: rtl/ratdiv_acc.sv
`timescale 1ns/1ps
// Down-counting modular phase register; overflow is the subtract borrow.
module ratdiv_acc #(
  parameter int unsigned P  = 256,
  parameter int unsigned Q  = 78125,
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [AW-1:0] acc_q,
  output logic [AW-1:0] acc_nxt,
  output logic          borrow
);
  localparam logic [AW:0] STEP_PLUS1 = (AW+1)'(P + 1);
  localparam logic [AW:0] MODULUS    = (AW+1)'(Q);
  localparam logic [AW:0] ONE        = (AW+1)'(1);

  logic [AW:0] dec;
  logic [AW:0] sum;

  // acc - (P+1) borrows exactly when acc - P <= 0
  assign dec    = {1'b0, acc_q} - STEP_PLUS1;
  assign borrow = dec[AW];
  assign sum    = dec + ONE + (borrow ? MODULUS : '0);
  assign acc_nxt = sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= MODULUS[AW-1:0];
    end else if (en) begin
      acc_q <= acc_nxt;
    end
  end
endmodule

// File: rtl/ratdiv_out.sv
`timescale 1ns/1ps
// Registered strobe and square-wave outputs.
module ratdiv_out #(
  parameter int unsigned Q  = 78125,
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          borrow,
  input  logic [AW-1:0] acc_nxt,
  output logic          tick_q,
  output logic          sq_q
);
  localparam logic [AW-1:0] HALF = AW'((Q + 1) / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      sq_q   <= 1'b0;
    end else if (en) begin
      tick_q <= borrow;
      sq_q   <= (acc_nxt < HALF);
    end else begin
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ratdiv_top.sv
`timescale 1ns/1ps
module ratdiv_top #(
  parameter int unsigned NUM = 256,
  parameter int unsigned DEN = 78125
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic ovf_pulse,
  output logic sq_out
);
  import ratdiv_pkg::*;

  localparam int unsigned G   = gcd_u(NUM, DEN);
  localparam int unsigned P_R = NUM / G;
  localparam int unsigned Q_R = DEN / G;
  localparam int unsigned AW  = $clog2(Q_R + 1);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_nxt;
  logic          borrow;

  ratdiv_acc #(.P(P_R), .Q(Q_R), .AW(AW)) i_acc (
    .clk    (clk),
    .rst    (rst),
    .en     (run_en),
    .acc_q  (acc_q),
    .acc_nxt(acc_nxt),
    .borrow (borrow)
  );

  ratdiv_out #(.Q(Q_R), .AW(AW)) i_out (
    .clk    (clk),
    .rst    (rst),
    .en     (run_en),
    .borrow (borrow),
    .acc_nxt(acc_nxt),
    .tick_q (ovf_pulse),
    .sq_q   (sq_out)
  );
endmodule

// File: rtl/ratdiv_chk.sv
`timescale 1ns/1ps
module ratdiv_chk #(
  parameter int unsigned P  = 256,
  parameter int unsigned Q  = 78125,
  parameter int unsigned AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          tick,
  input logic          sq,
  input logic [AW-1:0] acc
);
  localparam int unsigned GAP_LO = Q / P;
  localparam int unsigned GAP_HI = (Q + P - 1) / P;
  localparam logic [AW-1:0] QV = AW'(Q);

  int unsigned gap;

  always_ff @(posedge clk) begin
    if (rst)       gap <= 0;
    else if (en)   gap <= tick ? 1 : gap + 1;
    else if (tick) gap <= 0;
  end

  a_r1_reset_load: assert property (@(posedge clk) rst |=> (acc == QV && !tick && !sq));
  a_r2_range: assert property (@(posedge clk) disable iff (rst) (acc >= 1 && acc <= QV));
  a_r3_single: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc == $past(acc) && !tick && sq == $past(sq)));
  a_r5_low_at_wrap: assert property (@(posedge clk) disable iff (rst) tick |-> !sq);
  a_r6_gap: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == GAP_LO || gap == GAP_HI));
  a_r7_return: assert property (@(posedge clk) disable iff (rst)
    en |=> (acc != QV || tick));
endmodule

bind ratdiv_top ratdiv_chk #(.P(P_R), .Q(Q_R), .AW(AW)) i_chk (
  .clk (clk),
  .rst (rst),
  .en  (run_en),
  .tick(ovf_pulse),
  .sq  (sq_out),
  .acc (acc_q)
);

// File: tb/test_ratdiv_top.sv
`timescale 1ns/1ps
module test_ratdiv_top;
  localparam longint P1 = 256;
  localparam longint Q1 = 78125;
  localparam longint P2 = 3;   // 6/20 reduced
  localparam longint Q2 = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic t1, s1, t2, s2;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #10 clk = ~clk;

  ratdiv_top i_ratdiv_top (.clk(clk), .rst(rst), .run_en(en), .ovf_pulse(t1), .sq_out(s1));
  ratdiv_top #(.NUM(6), .DEN(20)) i_ratdiv_small (.clk(clk), .rst(rst), .run_en(en),
                                                 .ovf_pulse(t2), .sq_out(s2));

  typedef struct {
    logic   rst;
    logic   en;
    logic   t1;
    logic   s1;
    logic   t2;
    logic   s2;
    longint k;
  } exp_t;

  exp_t   sb[$];
  longint k = 0;
  longint k2 = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes its expected result
  task automatic drive(input logic r, input logic e);
    exp_t x;
    @(negedge clk);
    rst = r;
    en  = e;
    if (r) begin
      k = 0; k2 = 0;
    end else if (e) begin
      k++; k2++;
    end
    x.rst = r; x.en = e; x.k = k;
    if (r) begin
      x.t1 = 0; x.s1 = 0; x.t2 = 0; x.s2 = 0;
    end else begin
      x.t1 = e && (((k * P1) / Q1) != (((k - 1) * P1) / Q1));
      x.s1 = (Q1 - ((k * P1) % Q1)) < ((Q1 + 1) / 2);
      x.t2 = e && (((k2 * P2) / Q2) != (((k2 - 1) * P2) / Q2));
      x.s2 = (Q2 - ((k2 * P2) % Q2)) < ((Q2 + 1) / 2);
    end
    sb.push_back(x);
  endtask

  // monitor: compares after each edge
  longint gap = 0;
  longint ticks = 0;
  logic   prev_t = 0;
  always @(posedge clk) begin
    exp_t x;
    string tg;
    #2;
    if (sb.size() > 0) begin
      x  = sb.pop_front();
      tg = x.rst ? "R1" : (!x.en ? "R4" : (x.t1 ? "R2" : "R5"));
      chk({tg, " strobe"}, t1, x.t1);
      chk({tg, " square"}, s1, x.s1);
      chk("R8 strobe", t2, x.t2);
      chk("R8 square", s2, x.s2);
      if (x.rst) begin
        gap = 0; ticks = 0;
      end else begin
        if (x.en) gap++;
        if (t1) begin
          ticks++;
          chk("R3 adjacent", prev_t, 0);
          chk("R6 gap", ((gap == Q1 / P1) || (gap == (Q1 + P1 - 1) / P1)), 1);
          gap = 0;
        end
        if (x.en && x.k == Q1) chk("R7 strobes per period", ticks, P1);
      end
      prev_t = t1;
    end
  end

  initial begin
    repeat (3) drive(1, 0);
    repeat (1500) drive(0, 1);
    for (int i = 0; i < 3000; i++) drive(0, ((i % 7) != 3) && ((i % 11) != 0));
    repeat (40) drive(0, 0);
    repeat (2) drive(1, 1);
    for (int i = 0; i < Q1 + 700; i++) drive(0, 1);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule